// File: doc/BRIEF.md
# SATA Out-of-Band Sequence Transmitter

This block drives the out-of-band signalling controls of a serial transceiver for a SATA link. A one-cycle start pulse, together with a sequence kind and a link generation, launches a sequence. The sequence is a fixed number of data bursts. During a burst the transmitter leaves electrical idle and the block enables the alignment data pattern. Each burst is followed by an electrical-idle gap. The gap length depends on the sequence kind. The burst and gap lengths in clock cycles scale with the generation, because each generation runs the block at a different clock rate.

Completion does not come from the transceiver. A local timeout counter, loaded from a lookup indexed by generation and sequence kind, raises a one-cycle finished strobe. A completion flag from the transceiver can still belong to an earlier sequence, so it is not used.

The block also filters the received electrical-idle indication. The filter removes short spikes before the indication reaches the link state machine.

Top module: `sata_oob_tx`

## Requirements
- R1: While reset is low and in the first cycle after it, tx_eidle_o=1, burst_en_o=0, done_o=0 and rx_eidle_o=1.
- R2: A start_i sampled high while no sequence is running is accepted: in the next cycle burst_en_o=1 and tx_eidle_o=0.
- R3: Each burst lasts BURST_G1<<g cycles. g is gen_i latched at acceptance, and codes 0, 1 and 2 select ×1, ×2 and ×4, with code 3 treated as 2. tx_eidle_o is the complement of burst_en_o throughout.
- R4: Each gap lasts the burst length times 3 for seq_i code 0 (COMINIT/COMRESET), times 1 for code 1 (COMWAKE), times 9 for code 2 (COMSAS) and times 3 for the spare code 3.
- R5: A sequence is NUM_BURSTS bursts, and each burst is followed by its gap.
- R6: done_o is high for exactly one cycle, T cycles after the first burst cycle, where T = NUM_BURSTS×(burst+gap). tx_eidle_o is 1 in that cycle.
- R7: start_i sampled high during a sequence, or on the edge that raises done_o, is ignored. Changes of seq_i and gen_i during a sequence have no effect on it.
- R8: When no sequence is running, tx_eidle_o=1 and burst_en_o=0.
- R9: rx_eidle_o takes a new level of rx_eidle_i only after that level has been sampled on FILT_LEN consecutive edges. Shorter excursions leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; its rate depends on the link generation |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request pulse |
| seq_i | input | 2 | Sequence kind: 0 COMINIT/COMRESET, 1 COMWAKE, 2 COMSAS, 3 spare |
| gen_i | input | 2 | Link generation: 0, 1, 2 (3 treated as 2) |
| rx_eidle_i | input | 1 | Raw received electrical-idle indication |
| tx_eidle_o | output | 1 | Transmitter electrical-idle control |
| burst_en_o | output | 1 | Enables the burst data pattern |
| done_o | output | 1 | One-cycle sequence-finished strobe |
| rx_eidle_o | output | 1 | Filtered received electrical-idle indication |

## Verification
The assertions assume the following about the inputs:
- start_i, seq_i and gen_i are synchronous to clk_i.
- rx_eidle_i changes only between clock edges.
- A start may arrive at any time, including while a sequence is running. The design must absorb such a start.

The stimulus keeps to this. Every input is driven on the falling edge. Random runs deliberately toggle start_i, seq_i and gen_i during active sequences and on the finishing edge. The received-idle input is driven with random runs, some shorter and some longer than the filter length.

// File: rtl/sata_oob_pkg.sv
package sata_oob_pkg;

  typedef enum logic [1:0] {
    OOB_INIT = 2'd0,
    OOB_WAKE = 2'd1,
    OOB_SAS  = 2'd2,
    OOB_RSVD = 2'd3
  } oob_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_BURST = 2'd1,
    PH_GAP   = 2'd2
  } oob_phase_e;

  localparam int unsigned GAP_MULT_MAX = 9;
  localparam int unsigned GEN_MAX      = 2;

  // gap length in units of one burst
  function automatic int unsigned gap_mult(logic [1:0] kind);
    case (kind)
      OOB_WAKE: return 1;
      OOB_SAS:  return GAP_MULT_MAX;
      default:  return 3;
    endcase
  endfunction

endpackage

// File: rtl/oob_timing_lut.sv
module oob_timing_lut
  import sata_oob_pkg::*;
#(
  parameter int unsigned BURST_G1   = 8,
  parameter int unsigned NUM_BURSTS = 6,
  parameter int unsigned CNT_W      = 11
) (
  input  logic [1:0]       gen_i,
  input  logic [1:0]       kind_i,
  output logic [CNT_W-1:0] burst_len_o,
  output logic [CNT_W-1:0] gap_len_o,
  output logic [CNT_W-1:0] total_len_o
);

  localparam int unsigned NGEN = GEN_MAX + 1;

  logic [CNT_W-1:0] burst_tab [NGEN];
  logic [1:0]       gsel;

  for (genvar g = 0; g < NGEN; g++) begin : g_rate
    assign burst_tab[g] = CNT_W'(BURST_G1 << g);
  end

  assign gsel = (gen_i > 2'(GEN_MAX)) ? 2'(GEN_MAX) : gen_i;

  always_comb begin
    burst_len_o = burst_tab[gsel];
    gap_len_o   = CNT_W'(gap_mult(kind_i)) * burst_len_o;
    total_len_o = CNT_W'(NUM_BURSTS) * (burst_len_o + gap_len_o);
  end

endmodule

// File: rtl/oob_burst_seq.sv
module oob_burst_seq
  import sata_oob_pkg::*;
#(
  parameter int unsigned NUM_BURSTS = 6,
  parameter int unsigned CNT_W      = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [CNT_W-1:0] burst_len_i,
  input  logic [CNT_W-1:0] gap_len_i,
  output logic             burst_o,
  output logic             active_o
);

  localparam int unsigned NB_W = $clog2(NUM_BURSTS + 1);

  oob_phase_e       ph_q;
  logic [CNT_W-1:0] pcnt_q;
  logic [NB_W-1:0]  nb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      pcnt_q <= '0;
      nb_q   <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (go_i) begin
          ph_q   <= PH_BURST;
          pcnt_q <= '0;
          nb_q   <= '0;
        end
        PH_BURST: if (pcnt_q == burst_len_i - CNT_W'(1)) begin
          ph_q   <= PH_GAP;
          pcnt_q <= '0;
        end else begin
          pcnt_q <= pcnt_q + CNT_W'(1);
        end
        PH_GAP: if (pcnt_q == gap_len_i - CNT_W'(1)) begin
          pcnt_q <= '0;
          if (nb_q == NB_W'(NUM_BURSTS - 1)) begin
            ph_q <= PH_IDLE;
          end else begin
            ph_q <= PH_BURST;
            nb_q <= nb_q + NB_W'(1);
          end
        end else begin
          pcnt_q <= pcnt_q + CNT_W'(1);
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign burst_o  = (ph_q == PH_BURST);
  assign active_o = (ph_q != PH_IDLE);

  // R5
  burst_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_BURST) |-> (nb_q < NB_W'(NUM_BURSTS)));

endmodule

// File: rtl/oob_done_timer.sv
module oob_done_timer #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [CNT_W-1:0] total_i,
  output logic             run_o,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end else if (run_q) begin
        if (cnt_q == total_i - CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign run_o  = run_q;
  assign done_o = done_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

endmodule

// File: rtl/eidle_filter.sv
module eidle_filter #(
  parameter int unsigned FILT_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic flt_o
);

  localparam int unsigned FW = $clog2(FILT_LEN + 1);

  logic [FW-1:0] cnt_q;
  logic          flt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      flt_q <= 1'b1;
    end else if (raw_i == flt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == FW'(FILT_LEN - 1)) begin
      cnt_q <= '0;
      flt_q <= raw_i;
    end else begin
      cnt_q <= cnt_q + FW'(1);
    end
  end

  assign flt_o = flt_q;

  // R9
  flt_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_q != $past(flt_q)) |-> ($past(raw_i) == flt_q));

endmodule

// File: rtl/sata_oob_tx.sv
module sata_oob_tx
  import sata_oob_pkg::*;
#(
  parameter int unsigned BURST_G1   = 8,
  parameter int unsigned NUM_BURSTS = 6,
  parameter int unsigned FILT_LEN   = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] seq_i,
  input  logic [1:0] gen_i,
  input  logic       rx_eidle_i,
  output logic       tx_eidle_o,
  output logic       burst_en_o,
  output logic       done_o,
  output logic       rx_eidle_o
);

  localparam int unsigned MAX_TOTAL =
    NUM_BURSTS * (BURST_G1 << GEN_MAX) * (1 + GAP_MULT_MAX);
  localparam int unsigned CNT_W = $clog2(MAX_TOTAL + 1);

  logic             busy, accept, seq_active, burst;
  logic [1:0]       gen_q, kind_q;
  logic [CNT_W-1:0] burst_len, gap_len, total_len;

  assign accept = start_i & ~busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_q  <= '0;
      kind_q <= OOB_INIT;
    end else if (accept) begin
      gen_q  <= gen_i;
      kind_q <= seq_i;
    end
  end

  oob_timing_lut #(
    .BURST_G1  (BURST_G1),
    .NUM_BURSTS(NUM_BURSTS),
    .CNT_W     (CNT_W)
  ) u_lut (
    .gen_i      (gen_q),
    .kind_i     (kind_q),
    .burst_len_o(burst_len),
    .gap_len_o  (gap_len),
    .total_len_o(total_len)
  );

  oob_burst_seq #(
    .NUM_BURSTS(NUM_BURSTS),
    .CNT_W     (CNT_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (accept),
    .burst_len_i(burst_len),
    .gap_len_i  (gap_len),
    .burst_o    (burst),
    .active_o   (seq_active)
  );

  // completion is local; the transceiver flag may be stale
  oob_done_timer #(
    .CNT_W(CNT_W)
  ) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (accept),
    .total_i(total_len),
    .run_o  (busy),
    .done_o (done_o)
  );

  eidle_filter #(
    .FILT_LEN(FILT_LEN)
  ) u_rxf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i (rx_eidle_i),
    .flt_o (rx_eidle_o)
  );

  assign burst_en_o = burst;
  assign tx_eidle_o = ~burst;

  // R2
  accept_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy) |=> (burst_en_o && !tx_eidle_o));

  // R6
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (tx_eidle_o && !seq_active));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (tx_eidle_o && !burst_en_o));

  // R7
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && start_i) |=> ($stable(gen_q) && $stable(kind_q)));

endmodule

// File: tb/sata_oob_tx_bench.sv
module sata_oob_tx_bench;

  localparam int BURST_G1   = 8;
  localparam int NUM_BURSTS = 6;
  localparam int FILT_LEN   = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] seq_i = 2'd0;
  logic [1:0] gen_i = 2'd0;
  logic       rx_eidle_i = 1'b1;
  logic       tx_eidle_o, burst_en_o, done_o, rx_eidle_o;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  sata_oob_tx #(
    .BURST_G1  (BURST_G1),
    .NUM_BURSTS(NUM_BURSTS),
    .FILT_LEN  (FILT_LEN)
  ) u_sata_oob_tx (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .seq_i     (seq_i),
    .gen_i     (gen_i),
    .rx_eidle_i(rx_eidle_i),
    .tx_eidle_o(tx_eidle_o),
    .burst_en_o(burst_en_o),
    .done_o    (done_o),
    .rx_eidle_o(rx_eidle_o)
  );

  // filter model from R9: run length of equal samples
  logic m_out = 1'b1;
  logic m_prev = 1'b1;
  int   m_run = 0;
  always @(posedge clk) begin
    if (!rst_ni) begin
      m_out = 1'b1; m_prev = 1'b1; m_run = 0;
    end else begin
      if (rx_eidle_i == m_prev) m_run = m_run + 1;
      else m_run = 1;
      m_prev = rx_eidle_i;
      if (m_run >= FILT_LEN) m_out = rx_eidle_i;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_burst(int g);
    return BURST_G1 << ((g > 2) ? 2 : g);
  endfunction

  function automatic int exp_gap(int s, int g);
    int m;
    m = (s == 1) ? 1 : (s == 2) ? 9 : 3;
    return m * exp_burst(g);
  endfunction

  task automatic run_seq(int s, int g, bit noise);
    int b, gp, tot, mism, first_bad, rises;
    logic prev;
    b = exp_burst(g); gp = exp_gap(s, g); tot = NUM_BURSTS * (b + gp);
    mism = 0; first_bad = -1; rises = 0; prev = 1'b0;
    @(negedge clk);
    start_i = 1'b1; seq_i = 2'(s); gen_i = 2'(g);
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < tot; k++) begin
      logic eb;
      eb = ((k % (b + gp)) < b);
      if (burst_en_o !== eb || tx_eidle_o !== !eb || done_o !== 1'b0) begin
        mism++;
        if (first_bad < 0) first_bad = k;
      end
      if (burst_en_o && !prev) rises++;
      prev = burst_en_o;
      if (noise) begin
        start_i = 1'($urandom % 2); seq_i = 2'($urandom); gen_i = 2'($urandom);
      end
      if (k == tot - 1) start_i = noise;
      @(negedge clk);
    end
    check(mism == 0, noise ? "R7 pattern under noise" : "R3 R4 burst/gap pattern",
          first_bad, -1);
    check(rises == NUM_BURSTS, "R5 burst count", rises, NUM_BURSTS);
    check(done_o === 1'b1 && tx_eidle_o === 1'b1, "R6 done at T", done_o, 1);
    start_i = 1'b0;
    @(negedge clk);
    check(done_o === 1'b0 && burst_en_o === 1'b0 && tx_eidle_o === 1'b1,
          "R7 start on done edge ignored / R6 one cycle", {done_o, burst_en_o}, 0);
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5a17));
    repeat (2) @(negedge clk);
    check(tx_eidle_o === 1'b1 && burst_en_o === 1'b0 && done_o === 1'b0 &&
          rx_eidle_o === 1'b1, "R1 reset state", {tx_eidle_o, burst_en_o, done_o}, 4);
    rst_ni = 1'b1;
    @(negedge clk);
    check(tx_eidle_o === 1'b1 && burst_en_o === 1'b0 && done_o === 1'b0,
          "R1 after reset", burst_en_o, 0);

    // R8: idle with changing seq/gen and no start
    begin
      int bad = 0;
      for (int i = 0; i < 10; i++) begin
        seq_i = 2'($urandom); gen_i = 2'($urandom);
        @(negedge clk);
        if (tx_eidle_o !== 1'b1 || burst_en_o !== 1'b0 || done_o !== 1'b0) bad++;
      end
      check(bad == 0, "R8 idle hold", bad, 0);
    end

    // R2: first cycle after accept
    @(negedge clk);
    start_i = 1'b1; seq_i = 2'd1; gen_i = 2'd0;
    @(negedge clk);
    start_i = 1'b0;
    check(burst_en_o === 1'b1 && tx_eidle_o === 1'b0, "R2 accept", burst_en_o, 1);
    repeat (NUM_BURSTS * 2 * BURST_G1 + 2) @(negedge clk);

    // directed: every kind, clamped generation
    for (int s = 0; s < 4; s++) run_seq(s, 0, 1'b0);
    run_seq(0, 1, 1'b0);
    run_seq(2, 2, 1'b0);
    run_seq(1, 3, 1'b0);

    // random with mid-sequence noise
    for (int i = 0; i < 8; i++) run_seq(int'($urandom % 4), int'($urandom % 4), 1'b1);

    // R9 directed: short spike ignored
    begin
      int bad = 0;
      @(negedge clk);
      rx_eidle_i = 1'b0;
      for (int i = 0; i < FILT_LEN - 1; i++) begin
        @(negedge clk);
        if (rx_eidle_o !== 1'b1) bad++;
      end
      rx_eidle_i = 1'b1;
      repeat (FILT_LEN + 1) begin
        @(negedge clk);
        if (rx_eidle_o !== 1'b1) bad++;
      end
      check(bad == 0, "R9 spike suppressed", bad, 0);
    end
    // R9 directed: held level passes after FILT_LEN edges
    rx_eidle_i = 1'b0;
    for (int m = 1; m <= FILT_LEN + 1; m++) begin
      @(negedge clk);
      check(rx_eidle_o === ((m >= FILT_LEN) ? 1'b0 : 1'b1), "R9 hold latency",
            rx_eidle_o, (m >= FILT_LEN) ? 0 : 1);
    end
    // R9 random runs against the model
    begin
      int bad = 0;
      for (int i = 0; i < 400; i++) begin
        if ($urandom % 4 == 0) rx_eidle_i = ~rx_eidle_i;
        @(negedge clk);
        if (rx_eidle_o !== m_out) bad++;
      end
      check(bad == 0, "R9 random filter", bad, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule